// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Clear

This block is a watchdog that counts cycles of a slow clock and fires when software stops servicing it. Software services it through a handshake: two distinct clear strobes must both arrive, one after the other in either order, before the count restarts and the status flags drop. A strobe repeated on its own has no effect. An alternative configuration accepts a single clear strobe instead, which acts at once.

A halt strobe restarts the count and records entry into power-down through a status flag. When the counter expires, the block raises a one-cycle reset pulse if the system is running. If the power-down indicator is high, it raises a one-cycle wake pulse instead, so a sleeping system can wake at a fixed interval. Every expiry sets a time-out flag. A 2-bit tap select chooses one of four timeout periods.

Top module: `wdt_pair_guard`

## Requirements
- R1: While `rst_n` is low, `wdt_rst_o`, `wake_o`, `to_o` and `pdf_o` are all 0, and any half-finished clear handshake is forgotten.
- R2: The counter expires P = 2^(CNT_W-3+tap_sel_i) cycles after reset release or after a restart. A restart is a completed clear or a halt. Counting to the expiry uses the clock edge on which the restart was sampled as edge 0.
- R3: With `pd_i` low, an expiry produces a `wdt_rst_o` pulse exactly one cycle wide, and counting resumes from zero. The next expiry follows P cycles later.
- R4: Every expiry sets `to_o`. Only reset, a halt or a completed clear lowers `to_o`.
- R5: With `pd_i` high, an expiry produces a one-cycle `wake_o` pulse and no `wdt_rst_o` pulse. The two pulses are never high together.
- R6: In paired mode (`single_mode_i`=0), `clr_a_i` followed later by `clr_b_i`, or `clr_b_i` followed by `clr_a_i`, restarts the counter. On the cycle after the second strobe, `to_o` and `pdf_o` are both 0.
- R7: In paired mode, repeating the strobe already pending has no effect, and `clr_one_i` has no effect. Both strobes in the same cycle also have no effect.
- R8: A halt or a reset cancels a pending half of the handshake, so a later lone opposite strobe does not restart the counter.
- R9: `halt_i` restarts the counter, sets `pdf_o` and clears `to_o`. It takes priority over a clear or an expiry in the same cycle.
- R10: In single mode (`single_mode_i`=1), `clr_one_i` restarts the counter and clears `to_o` and `pdf_o`. In this mode `clr_a_i` and `clr_b_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Active-low power-up reset |
| tap_sel_i | input | 2 | Period select, 0 shortest to 3 longest |
| single_mode_i | input | 1 | 1: single-strobe clear, 0: two-step clear |
| clr_a_i | input | 1 | First clear strobe of the pair |
| clr_b_i | input | 1 | Second clear strobe of the pair |
| clr_one_i | input | 1 | Single-strobe clear |
| halt_i | input | 1 | Halt strobe |
| pd_i | input | 1 | Power-down indicator level |
| wdt_rst_o | output | 1 | One-cycle reset pulse on expiry |
| wake_o | output | 1 | One-cycle wake pulse on expiry in power-down |
| to_o | output | 1 | Time-out status flag |
| pdf_o | output | 1 | Power-down status flag |

## Verification
A wrong handshake state appears only as a shift in when the next expiry pulse arrives. The bench therefore measures the cycle distance from each command to the following pulse, and a restart that is lost or made up shows as a count that is off by the cycles since the last restart. A pending half that survives a halt or reset is caught within one period. A flag that updates wrongly is visible on the cycle after the event that should have moved it.

// File: rtl/wdtg_pkg.sv
package wdtg_pkg;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_A    = 2'd1,
    PEND_B    = 2'd2
  } pend_e;

  // timeout period in cycles for a counter of width w and a tap select
  function automatic logic [31:0] wdtg_period(input int unsigned w, input logic [1:0] sel);
    return 32'd1 << (w - 32'd3 + 32'(sel));
  endfunction

endpackage

// File: rtl/wdtg_pair_fsm.sv
module wdtg_pair_fsm
  import wdtg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic single_mode_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  input  logic clr_one_i,
  input  logic halt_i,
  output logic fire_o
);

  pend_e state_q, state_d;
  logic  a_only, b_only;

  assign a_only = clr_a_i & ~clr_b_i;
  assign b_only = clr_b_i & ~clr_a_i;

  always_comb begin
    state_d = state_q;
    fire_o  = 1'b0;
    if (halt_i) begin
      state_d = PEND_NONE;
    end else if (single_mode_i) begin
      state_d = PEND_NONE;
      fire_o  = clr_one_i;
    end else begin
      unique case (state_q)
        PEND_NONE: begin
          if (a_only)      state_d = PEND_A;
          else if (b_only) state_d = PEND_B;
        end
        PEND_A: if (b_only) begin
          fire_o  = 1'b1;
          state_d = PEND_NONE;
        end
        PEND_B: if (a_only) begin
          fire_o  = 1'b1;
          state_d = PEND_NONE;
        end
        default: state_d = PEND_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PEND_NONE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/wdtg_counter.sv
module wdtg_counter
  import wdtg_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       tap_sel_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  logic [31:0] period;

  assign period = wdtg_period(CNT_W, tap_sel_i);
  assign ovf_o  = !restart_i && (32'(cnt_o) == period - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_o <= '0;
    else if (restart_i || ovf_o) cnt_o <= '0;
    else                         cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/wdtg_flags.sv
module wdtg_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_i,
  input  logic pd_i,
  input  logic halt_i,
  input  logic fire_i,
  output logic wdt_rst_o,
  output logic wake_o,
  output logic to_o,
  output logic pdf_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_rst_o <= 1'b0;
      wake_o    <= 1'b0;
      to_o      <= 1'b0;
      pdf_o     <= 1'b0;
    end else begin
      wdt_rst_o <= ovf_i & ~pd_i;
      wake_o    <= ovf_i & pd_i;
      if (halt_i) begin
        pdf_o <= 1'b1;
        to_o  <= 1'b0;
      end else if (fire_i) begin
        pdf_o <= 1'b0;
        to_o  <= 1'b0;
      end else if (ovf_i) begin
        to_o  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdt_pair_guard.sv
module wdt_pair_guard #(
  parameter int unsigned CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tap_sel_i,
  input  logic       single_mode_i,
  input  logic       clr_a_i,
  input  logic       clr_b_i,
  input  logic       clr_one_i,
  input  logic       halt_i,
  input  logic       pd_i,
  output logic       wdt_rst_o,
  output logic       wake_o,
  output logic       to_o,
  output logic       pdf_o
);

  logic             pair_fire;
  logic             restart;
  logic             ovf;
  logic [CNT_W-1:0] cnt_q;

  assign restart = pair_fire | halt_i;

  wdtg_pair_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .single_mode_i(single_mode_i),
    .clr_a_i(clr_a_i), .clr_b_i(clr_b_i), .clr_one_i(clr_one_i),
    .halt_i(halt_i), .fire_o(pair_fire)
  );

  wdtg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tap_sel_i(tap_sel_i),
    .restart_i(restart), .cnt_o(cnt_q), .ovf_o(ovf)
  );

  wdtg_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ovf_i(ovf), .pd_i(pd_i),
    .halt_i(halt_i), .fire_i(pair_fire),
    .wdt_rst_o(wdt_rst_o), .wake_o(wake_o), .to_o(to_o), .pdf_o(pdf_o)
  );

endmodule

// File: rtl/wdt_pair_guard_chk.sv
module wdt_pair_guard_chk #(
  parameter int unsigned CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             single_mode_i,
  input logic             clr_a_i,
  input logic             clr_b_i,
  input logic             clr_one_i,
  input logic             halt_i,
  input logic             pair_fire,
  input logic             restart,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wdt_rst_o,
  input logic             wake_o,
  input logic             to_o,
  input logic             pdf_o
);

  p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);

  p_pulse_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> !wdt_rst_o);

  p_expiry_sets_to_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst_o || wake_o) |-> to_o);

  p_pulse_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_rst_o && wake_o));

  p_pair_clears_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_fire && !halt_i) |=> (!to_o && !pdf_o));

  p_halt_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> (pdf_o && !to_o));

  p_single_ignores_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (single_mode_i && !clr_one_i && (clr_a_i || clr_b_i)) |-> !pair_fire);

endmodule

bind wdt_pair_guard wdt_pair_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .single_mode_i(single_mode_i),
  .clr_a_i(clr_a_i), .clr_b_i(clr_b_i), .clr_one_i(clr_one_i),
  .halt_i(halt_i), .pair_fire(pair_fire), .restart(restart),
  .cnt_q(cnt_q), .wdt_rst_o(wdt_rst_o), .wake_o(wake_o),
  .to_o(to_o), .pdf_o(pdf_o)
);

// File: tb/wdt_pair_guard_test.sv
`timescale 1ns/1ps
module wdt_pair_guard_test;

  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] tap_sel_i = 2'd0;
  logic       single_mode_i = 1'b0;
  logic       clr_a_i = 1'b0, clr_b_i = 1'b0, clr_one_i = 1'b0;
  logic       halt_i = 1'b0, pd_i = 1'b0;
  logic       wdt_rst_o, wake_o, to_o, pdf_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdt_pair_guard #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tap_sel_i(tap_sel_i), .single_mode_i(single_mode_i),
    .clr_a_i(clr_a_i), .clr_b_i(clr_b_i), .clr_one_i(clr_one_i),
    .halt_i(halt_i), .pd_i(pd_i),
    .wdt_rst_o(wdt_rst_o), .wake_o(wake_o), .to_o(to_o), .pdf_o(pdf_o)
  );

  function automatic int per(input int sel);
    return 2 ** (W - 3 + sel);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // drive one-cycle strobe: 0=a 1=b 2=one 3=halt
  task automatic cmd(input int k);
    clr_a_i = (k == 0); clr_b_i = (k == 1); clr_one_i = (k == 2); halt_i = (k == 3);
    @(negedge clk);
    clr_a_i = 0; clr_b_i = 0; clr_one_i = 0; halt_i = 0;
  endtask

  task automatic wait_evt(output int n, output bit woke);
    n = 0; woke = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wdt_rst_o && !wake_o && n < 1000);
    woke = wake_o;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    bit woke;
    // R2/R3/R4 sweep over all taps
    for (int s = 0; s < 4; s++) begin
      rst_n = 0; tap_sel_i = 2'(s);
      step(); step();
      rst_n = 1;
      wait_evt(n, woke);
      chk(n == per(s), "R2 first expiry", n, per(s));
      chk(to_o == 1'b1, "R4 to set", to_o, 1);
      step();
      chk(wdt_rst_o == 1'b0, "R3 pulse width", wdt_rst_o, 0);
      wait_evt(n, woke);
      chk(n == per(s) - 1, "R3 second expiry", n, per(s) - 1);
    end

    // R1 reset state
    rst_n = 0; tap_sel_i = 2'd0;
    step();
    chk({wdt_rst_o, wake_o, to_o, pdf_o} == 4'b0, "R1 reset outputs",
        {wdt_rst_o, wake_o, to_o, pdf_o}, 0);
    step();
    rst_n = 1;
    wait_evt(n, woke);
    chk(n == per(0), "R2 after reset", n, per(0));

    // R6 a then b
    repeat (5) step();
    cmd(0);
    chk(to_o == 1'b1, "R6 half pair keeps to", to_o, 1);
    repeat (3) step();
    cmd(1);
    chk(to_o == 1'b0, "R6 pair clears to", to_o, 0);
    wait_evt(n, woke);
    chk(n == per(0), "R6 a-b restart", n, per(0));

    // R6 b then a
    cmd(1); cmd(0);
    wait_evt(n, woke);
    chk(n == per(0), "R6 b-a restart", n, per(0));

    // R7 repeated strobe (leaves A pending)
    cmd(0); cmd(0);
    wait_evt(n, woke);
    chk(n == per(0) - 2, "R7 repeat ignored", n, per(0) - 2);

    // R7 single strobe ignored in paired mode
    cmd(2);
    wait_evt(n, woke);
    chk(n == per(0) - 1, "R7 single strobe ignored", n, per(0) - 1);

    // R9 halt
    cmd(3);
    chk(pdf_o == 1'b1, "R9 pdf set", pdf_o, 1);
    chk(to_o == 1'b0, "R9 to cleared", to_o, 0);
    // R8 halt cancelled pending A: lone b does not restart
    cmd(1);
    wait_evt(n, woke);
    chk(n == per(0) - 1, "R8 halt cancels pending", n, per(0) - 1);
    chk(pdf_o == 1'b1, "R4 expiry keeps pdf", pdf_o, 1);

    // R6 completes pending B, clears both flags
    cmd(0);
    chk({to_o, pdf_o} == 2'b00, "R6 pair clears to and pdf", {to_o, pdf_o}, 0);

    // R5 power-down wake
    pd_i = 1;
    wait_evt(n, woke);
    chk(n == per(0), "R5 wake timing", n, per(0));
    chk(woke && !wdt_rst_o, "R5 wake not reset", {woke, wdt_rst_o}, 2);
    chk(to_o == 1'b1, "R5 to on wake", to_o, 1);
    step();
    pd_i = 0;
    chk(wake_o == 1'b0, "R5 wake width", wake_o, 0);
    wait_evt(n, woke);
    chk(n == per(0) - 1 && !woke, "R5 reset after pd drops", n, per(0) - 1);

    // R10 single mode
    single_mode_i = 1;
    cmd(0); cmd(1);
    wait_evt(n, woke);
    chk(n == per(0) - 2, "R10 pair strobes ignored", n, per(0) - 2);
    cmd(3);
    cmd(2);
    chk({to_o, pdf_o} == 2'b00, "R10 single clears flags", {to_o, pdf_o}, 0);
    wait_evt(n, woke);
    chk(n == per(0), "R10 single restart", n, per(0));

    // R8 reset cancels pending
    single_mode_i = 0;
    cmd(0);
    rst_n = 0;
    step();
    rst_n = 1;
    cmd(1);
    wait_evt(n, woke);
    chk(n == per(0) - 1, "R8 reset cancels pending", n, per(0) - 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule